// File: doc/BRIEF.md
# Mode-Banked Register Index Mapper

This block converts an architectural register number (0 to 15) and the 5-bit processor mode field into the index of an entry in a flat, banked physical register file. For the same mode it also reports whether a saved status register exists, which of the six saved-status slots belongs to that mode, and whether the mode field holds a legal encoding at all. A write-request input is turned into a physical write enable. That enable is held low whenever the mode is illegal, so a corrupt mode field cannot overwrite the shared bank.

One level of logic selects a mode class and a second computes the index from that class. The results then pass either straight to the outputs or through one register stage, as chosen by the `REG_OUT` parameter. The physical layout is fixed in the package. Entries 0 to 15 are the shared copies of R0 to R15. Entries 16 to 22 hold the private FIQ R8 to R14. Entries 23 to 32 hold the private R13/R14 pairs of IRQ, Supervisor, Abort, Undefined and Monitor, in that order.

Top module: `mode_bank_mapper`

## Requirements
- R1: R0 to R7 map to physical index equal to the register number in every mode, and R8 to R12 do the same in every mode other than FIQ.
- R2: In FIQ mode (mode 5'b10001), R8 to R14 map to physical index register number plus 8 (16 to 22).
- R3: In IRQ (5'b10010), Supervisor (5'b10011), Abort (5'b10111), Undefined (5'b11011) and Monitor (5'b10110), R13 and R14 map to a private pair starting at 23, 25, 27, 29 and 31 respectively, with R13 first.
- R4: R15 maps to physical index 15 in every mode, legal or not.
- R5: User (5'b10000) and System (5'b11111) map every register to its own number, drive spsr_present_o low and drive spsr_idx_o to 0.
- R6: The six exception modes drive spsr_present_o high with spsr_idx_o FIQ=0, IRQ=1, Supervisor=2, Abort=3, Undefined=4, Monitor=5.
- R7: Any mode encoding outside the eight listed raises invalid_mode_o, maps registers exactly as User mode does and reports no saved status register.
- R8: phys_wr_o is high exactly when wr_i is high and the mode is legal.
- R9: With REG_OUT=1 (default), all outputs reflect the inputs sampled at the previous rising clock edge, and an active-low reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| mode_i | input | 5 | Current processor mode field |
| reg_i | input | 4 | Architectural register number |
| wr_i | input | 1 | 1 = write access, 0 = read access |
| phys_idx_o | output | 6 | Physical register file index |
| phys_wr_o | output | 1 | Write enable qualified by mode legality |
| spsr_present_o | output | 1 | Mode owns a saved status register |
| spsr_idx_o | output | 3 | Saved status register slot |
| invalid_mode_o | output | 1 | Mode field is not a legal encoding |

## Verification
With the default registered output, every result is due exactly one rising edge after the inputs it answers to. The bench drives on the falling edge and samples 1 ns after the next rising edge. One directed check also samples just before that rising edge, to confirm that the outputs still hold the earlier answer. All 32 mode codes are crossed with all 16 register numbers and both access types, and seeded random vectors follow. Reset values are read while reset is held.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;
  localparam int MODE_W       = 5;
  localparam int ARCH_W       = 4;
  localparam int SHARED_CNT   = 1 << ARCH_W;          // R0..R15 shared copies
  localparam int FIQ_FIRST    = 8;                    // first FIQ-banked register
  localparam int SP_NUM       = 13;                   // first pair-banked register
  localparam int PC_NUM       = SHARED_CNT - 1;
  localparam int FIQ_BASE     = SHARED_CNT;
  localparam int FIQ_CNT      = PC_NUM - FIQ_FIRST;   // R8..R14
  localparam int PAIR_MODES   = 5;
  localparam int PAIR_CNT     = PC_NUM - SP_NUM;      // R13, R14
  localparam int PAIR_BASE    = FIQ_BASE + FIQ_CNT;
  localparam int PHYS_ENTRIES = PAIR_BASE + PAIR_MODES * PAIR_CNT;
  localparam int PHYS_W       = $clog2(PHYS_ENTRIES);
  localparam int SPSR_CNT     = PAIR_MODES + 1;
  localparam int SPSR_W       = $clog2(SPSR_CNT);

  typedef logic [MODE_W-1:0] mode_t;
  typedef logic [ARCH_W-1:0] areg_t;
  typedef logic [PHYS_W-1:0] preg_t;
  typedef logic [SPSR_W-1:0] sidx_t;

  // class value doubles as saved-status slot for exception modes
  typedef enum logic [2:0] {
    MC_FIQ = 3'd0, MC_IRQ = 3'd1, MC_SVC = 3'd2, MC_ABT = 3'd3,
    MC_UND = 3'd4, MC_MON = 3'd5, MC_USR = 3'd7
  } mode_class_e;

  localparam mode_t ENC_USR = 5'b10000;
  localparam mode_t ENC_FIQ = 5'b10001;
  localparam mode_t ENC_IRQ = 5'b10010;
  localparam mode_t ENC_SVC = 5'b10011;
  localparam mode_t ENC_MON = 5'b10110;
  localparam mode_t ENC_ABT = 5'b10111;
  localparam mode_t ENC_UND = 5'b11011;
  localparam mode_t ENC_SYS = 5'b11111;

  typedef struct packed {
    preg_t phys;
    logic  wr;
    logic  spsr_vld;
    sidx_t spsr_idx;
    logic  bad_mode;
  } map_res_t;

  function automatic logic mode_legal(mode_t m);
    case (m)
      ENC_USR, ENC_FIQ, ENC_IRQ, ENC_SVC,
      ENC_MON, ENC_ABT, ENC_UND, ENC_SYS: return 1'b1;
      default:                            return 1'b0;
    endcase
  endfunction

  function automatic mode_class_e classify(mode_t m);
    case (m)
      ENC_FIQ: return MC_FIQ;
      ENC_IRQ: return MC_IRQ;
      ENC_SVC: return MC_SVC;
      ENC_ABT: return MC_ABT;
      ENC_UND: return MC_UND;
      ENC_MON: return MC_MON;
      default: return MC_USR;   // User, System and illegal codes
    endcase
  endfunction

  function automatic preg_t phys_of(mode_class_e c, areg_t r);
    int ri;
    int ci;
    ri = int'(r);
    ci = int'(c);
    if (ri == PC_NUM)
      return preg_t'(PC_NUM);
    if (c == MC_FIQ && ri >= FIQ_FIRST)
      return preg_t'(FIQ_BASE + ri - FIQ_FIRST);
    if (c != MC_FIQ && c != MC_USR && ri >= SP_NUM)
      return preg_t'(PAIR_BASE + PAIR_CNT * (ci - 1) + ri - SP_NUM);
    return preg_t'(ri);
  endfunction
endpackage

// File: rtl/bm_mode_decode.sv
module bm_mode_decode
  import bankmap_pkg::*;
(
  input  mode_t       mode_i,
  output mode_class_e cls_o,
  output logic        bad_mode_o,
  output logic        spsr_vld_o,
  output sidx_t       spsr_idx_o
);
  mode_class_e cls_c;

  always_comb begin
    cls_c      = classify(mode_i);
    bad_mode_o = !mode_legal(mode_i);
    spsr_vld_o = (cls_c != MC_USR);
    spsr_idx_o = spsr_vld_o ? sidx_t'(cls_c) : '0;
  end

  assign cls_o = cls_c;

  always_comb begin
    AST_BAD_NO_SPSR: assert (!(bad_mode_o && spsr_vld_o));           // R7
    AST_SPSR_SLOT:   assert (!spsr_vld_o || spsr_idx_o < SPSR_CNT);  // R6
  end
endmodule

// File: rtl/bm_bank_map.sv
module bm_bank_map
  import bankmap_pkg::*;
(
  input  mode_class_e cls_i,
  input  areg_t       reg_i,
  output preg_t       phys_o
);
  assign phys_o = phys_of(cls_i, reg_i);

  always_comb begin
    AST_PHYS_RANGE: assert (phys_o < PHYS_ENTRIES);                            // R2
    AST_PC_SHARED:  assert (reg_i != areg_t'(PC_NUM) || phys_o == preg_t'(PC_NUM)); // R4
    AST_USR_FLAT:   assert (cls_i != MC_USR || phys_o == preg_t'(reg_i));      // R5
    AST_LOW_FLAT:   assert (reg_i >= areg_t'(FIQ_FIRST) || phys_o == preg_t'(reg_i)); // R1
  end
endmodule

// File: rtl/mode_bank_mapper.sv
module mode_bank_mapper
  import bankmap_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] mode_i,
  input  logic [3:0] reg_i,
  input  logic       wr_i,
  output logic [5:0] phys_idx_o,
  output logic       phys_wr_o,
  output logic       spsr_present_o,
  output logic [2:0] spsr_idx_o,
  output logic       invalid_mode_o
);
  mode_class_e cls_w;
  logic        bad_mode_w;
  logic        spsr_vld_w;
  sidx_t       spsr_idx_w;
  preg_t       phys_w;
  logic        wr_ok_w;
  map_res_t    res_c;
  map_res_t    res_q;

  bm_mode_decode u_dec (
    .mode_i     (mode_i),
    .cls_o      (cls_w),
    .bad_mode_o (bad_mode_w),
    .spsr_vld_o (spsr_vld_w),
    .spsr_idx_o (spsr_idx_w)
  );

  bm_bank_map u_map (
    .cls_i  (cls_w),
    .reg_i  (reg_i),
    .phys_o (phys_w)
  );

  assign wr_ok_w = wr_i && !bad_mode_w;

  always_comb begin
    res_c          = '0;
    res_c.phys     = phys_w;
    res_c.wr       = wr_ok_w;
    res_c.spsr_vld = spsr_vld_w;
    res_c.spsr_idx = spsr_idx_w;
    res_c.bad_mode = bad_mode_w;
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_c;
      end

      AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bad_mode_w) |-> !phys_wr_o);                              // R8
      AST_PC_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(reg_i) == areg_t'(PC_NUM))
          |-> phys_idx_o == preg_t'(PC_NUM));                           // R4
      AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(mode_i) && $stable(reg_i) && $past(rst_n, 2))
          |=> $stable(phys_idx_o));                                     // R9
    end else begin : g_comb
      assign res_q = res_c;
    end
  endgenerate

  assign phys_idx_o     = res_q.phys;
  assign phys_wr_o      = res_q.wr;
  assign spsr_present_o = res_q.spsr_vld;
  assign spsr_idx_o     = res_q.spsr_idx;
  assign invalid_mode_o = res_q.bad_mode;
endmodule

// File: tb/tb_mode_bank_mapper.sv
`timescale 1ns/1ps
module tb_mode_bank_mapper;
  localparam real HALF = 2.5;   // 200 MHz

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] mode_i = '0;
  logic [3:0] reg_i = '0;
  logic       wr_i = 1'b0;
  logic [5:0] phys_idx_o;
  logic       phys_wr_o;
  logic       spsr_present_o;
  logic [2:0] spsr_idx_o;
  logic       invalid_mode_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;
  int exp_tab [32][16];

  always #HALF clk = ~clk;

  mode_bank_mapper dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .reg_i(reg_i), .wr_i(wr_i),
    .phys_idx_o(phys_idx_o), .phys_wr_o(phys_wr_o),
    .spsr_present_o(spsr_present_o), .spsr_idx_o(spsr_idx_o),
    .invalid_mode_o(invalid_mode_o)
  );

  // -1 illegal, 0 user/system, 1 FIQ, 2 IRQ, 3 SVC, 4 ABT, 5 UND, 6 MON
  function automatic int ref_kind(int m);
    case (m)
      16, 31: return 0;
      17: return 1;
      18: return 2;
      19: return 3;
      23: return 4;
      27: return 5;
      22: return 6;
      default: return -1;
    endcase
  endfunction

  function automatic int ref_phys(int m, int r);
    int k;
    k = ref_kind(m);
    if (r == 15) return 15;
    if (k == 1 && r >= 8) return r + 8;
    if (k >= 2 && r >= 13) return r + 10 + 2 * (k - 2);
    return r;
  endfunction

  function automatic string phys_tag(int m, int r);
    int k;
    k = ref_kind(m);
    if (k < 0) return "R7";
    if (r == 15) return "R4";
    if (k == 1 && r >= 8) return "R2";
    if (k >= 2 && r >= 13) return "R3";
    if (k == 0) return "R5";
    return "R1";
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    if (act != exp) begin
      n_bad++;
      $display("FIL %s", "");
    end
  endtask

  task automatic check_now(int m, int r, bit w);
    int k;
    string st;
    k  = ref_kind(m);
    st = (k < 0) ? "R7" : (k == 0 ? "R5" : "R6");
    n_vec++;
    if (int'(phys_idx_o) != exp_tab[m][r]) begin
      n_bad++;
      $display("FAIL %s phys m=%0d r=%0d act=%0d exp=%0d", phys_tag(m, r), m, r, phys_idx_o, exp_tab[m][r]);
    end
    if (spsr_present_o != (k >= 1)) begin
      n_bad++;
      $display("FAIL %s spsr_present m=%0d act=%0d exp=%0d", st, m, spsr_present_o, (k >= 1));
    end
    if (int'(spsr_idx_o) != ((k >= 1) ? k - 1 : 0)) begin
      n_bad++;
      $display("FAIL %s spsr_idx m=%0d act=%0d exp=%0d", st, m, spsr_idx_o, (k >= 1) ? k - 1 : 0);
    end
    if (invalid_mode_o != (k < 0)) begin
      n_bad++;
      $display("FAIL R7 invalid m=%0d act=%0d exp=%0d", m, invalid_mode_o, (k < 0));
    end
    if (phys_wr_o != (w && k >= 0)) begin
      n_bad++;
      $display("FAIL R8 wr m=%0d w=%0d act=%0d exp=%0d", m, w, phys_wr_o, (w && k >= 0));
    end
  endtask

  // drive on falling edge, result due after one rising edge (R9)
  task automatic apply(int m, int r, bit w);
    @(negedge clk);
    mode_i = 5'(m);
    reg_i  = 4'(r);
    wr_i   = w;
    @(posedge clk);
    #1;
    check_now(m, r, w);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(2.0 * HALF * 100000);
    n_bad++;
    $display("FAIL R9 watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    for (int m = 0; m < 32; m++)
      for (int r = 0; r < 16; r++)
        exp_tab[m][r] = ref_phys(m, r);

    // reset state (R9)
    mode_i = 5'd17; reg_i = 4'd9; wr_i = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    n_vec++;
    if ({phys_idx_o, phys_wr_o, spsr_present_o, spsr_idx_o, invalid_mode_o} != '0) begin
      n_bad++;
      $display("FAIL R9 reset outputs act=%0h exp=0",
               {phys_idx_o, phys_wr_o, spsr_present_o, spsr_idx_o, invalid_mode_o});
    end
    @(negedge clk);
    rst_n = 1'b1;

    // directed corners
    apply(17, 14, 1'b0);   // R2 FIQ LR -> 22
    apply(22, 13, 1'b1);   // R3 Monitor SP -> 31
    apply(0, 15, 1'b1);    // R4 and R7 on illegal code, write blocked (R8)
    apply(31, 14, 1'b1);   // R5 System LR flat

    // latency: before the edge the old answer must still be visible (R9)
    @(negedge clk);
    mode_i = 5'd18; reg_i = 4'd13; wr_i = 1'b0;
    #1;
    n_vec++;
    if (phys_idx_o != 6'd14) begin
      n_bad++;
      $display("FAIL R9 early phys act=%0d exp=14", phys_idx_o);
    end
    @(posedge clk);
    #1;
    check_now(18, 13, 1'b0);

    // exhaustive sweep (R1..R8)
    for (int m = 0; m < 32; m++)
      for (int r = 0; r < 16; r++)
        for (int w = 0; w < 2; w++)
          apply(m, r, w[0]);

    // seeded random mix
    void'($urandom(32'd20240607));
    for (int i = 0; i < 400; i++) begin
      int m;
      int r;
      m = ($urandom % 4 == 0) ? int'($urandom % 32)
                              : int'(16 + ($urandom % 16));
      r = int'($urandom % 16);
      apply(m, r, 1'($urandom));
    end

    // reset asserted mid-run clears outputs again (R9)
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    n_vec++;
    if (phys_idx_o != 6'd0 || invalid_mode_o != 1'b0) begin
      n_bad++;
      $display("FAIL R9 async reset act=%0d exp=0", phys_idx_o);
    end
    finish_run();
  end
endmodule